// File: doc/BRIEF.md
# Load Multiple Word Sequencer

This block performs a load-multiple-word operation one register at a time. A start pulse supplies the first target register number (0 to 31) and an effective address that has already been computed. For every register from that number up to 31, the sequencer issues a 4-byte read on a valid/ready request channel and takes the word back on a valid/ready response channel. It then writes the word into the register file, zero-extended to 64 bits. After each write the register number goes up by one and the address goes up by four. A one-cycle done pulse follows the write of register 31.

There is never more than one read in flight. A request stays up with a stable address until the memory side accepts it, so the memory applies back-pressure through its ready. The block asserts response ready only while it waits for data, so a response can be held off until that point. The register write port has no back-pressure: the register file takes a write in the cycle it is presented. While the sequencer is busy, it ignores any start pulse.

Top module: `lmw_seq`

## Requirements
- R1: After reset, busy_o, done_o, rd_req_valid_o, rd_rsp_ready_o and gpr_we_o are all 0.
- R2: The first read request carries start_addr_i, and the first register write targets start_reg_i, both as sampled with start_i.
- R3: Each later request address is the previous one plus 4, and each later write index is the previous one plus 1.
- R4: gpr_wdata_o has bits 63:32 equal to 0 and bits 31:0 equal to the accepted response word.
- R5: A run makes exactly 32 minus start_reg_i register writes. The last write targets register 31, and done_o is 1 in the cycle after that write.
- R6: rd_req_valid_o, once raised, stays 1 with rd_req_addr_o unchanged until rd_req_ready_i is seen. No request is raised while a response is awaited.
- R7: A start_i pulse while busy_o is 1 has no effect: the write sequence and the request addresses continue unchanged.
- R8: done_o lasts exactly one cycle, and busy_o is 0 in the cycle after it.
- R9: rd_rsp_ready_o is 1 only while a response is awaited. gpr_we_o is 1 in the cycle after a response is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| start_reg_i | input | 5 | First target register number |
| start_addr_i | input | 64 | Effective address of the first word |
| busy_o | output | 1 | High from the accepted start until done |
| done_o | output | 1 | One-cycle completion pulse |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | 64 | Byte address of the 4-byte read |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_ready_o | output | 1 | Sequencer can take read data |
| rd_rsp_data_i | input | 32 | Read data word |
| gpr_we_o | output | 1 | Register write enable |
| gpr_waddr_o | output | 5 | Register write index |
| gpr_wdata_o | output | 64 | Zero-extended write data |

## Verification
The request appears one cycle after the start is sampled. The register write appears one cycle after the response handshake. The done pulse comes one cycle after the write of register 31, and busy falls one cycle after that. The memory model drives its ready and valid signals on the falling edge and varies its grant and response delays. The scoreboard compares each write against the queue head at the falling edge of the write cycle, and it checks done exactly one and two falling edges after the last write. Request addresses are compared at the falling edge before the handshake edge. Because of that, a stray start pulse or a lost step shows up as a wrong address or a wrong queued write.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_REQ   = 3'd1,
    S_WAIT  = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4
  } lmw_state_e;
endpackage

// File: rtl/lmw_ctrl.sv
module lmw_ctrl
  import lmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  input  logic       last_i,
  output lmw_state_e state_o,
  output logic       load_o,
  output logic       capture_o,
  output logic       advance_o
);
  lmw_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (start_i) st_d = S_REQ;
      S_REQ:   if (req_ready_i) st_d = S_WAIT;
      S_WAIT:  if (rsp_valid_i) st_d = S_WRITE;
      S_WRITE: st_d = last_i ? S_DONE : S_REQ;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign state_o   = st_q;
  assign load_o    = (st_q == S_IDLE) && start_i;
  assign capture_o = (st_q == S_WAIT) && rsp_valid_i;
  assign advance_o = (st_q == S_WRITE) && !last_i;

  // R8: the completion state is left after one cycle
  p_done_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DONE) |=> (st_q == S_IDLE));
endmodule

// File: rtl/lmw_step.sv
module lmw_step #(
  parameter int AW   = 64,
  parameter int NREG = 32,
  parameter int STEP = 4,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           advance_i,
  input  logic [RIW-1:0] start_reg_i,
  input  logic [AW-1:0]  start_addr_i,
  output logic [RIW-1:0] idx_o,
  output logic [AW-1:0]  addr_o,
  output logic           last_o
);
  localparam logic [RIW-1:0] LAST_IDX = RIW'(NREG - 1);
  localparam logic [AW-1:0]  ADDR_INC = AW'(STEP);

  logic [RIW-1:0] idx_q;
  logic [AW-1:0]  addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      idx_q  <= start_reg_i;
      addr_q <= start_addr_i;
    end else if (advance_i) begin
      idx_q  <= idx_q + 1'b1;
      addr_q <= addr_q + ADDR_INC;
    end
  end

  assign idx_o  = idx_q;
  assign addr_o = addr_q;
  assign last_o = (idx_q == LAST_IDX);

  // R3: the controller never steps past the final register
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |-> !last_o);
endmodule

// File: rtl/lmw_zext.sv
module lmw_zext #(
  parameter int WW   = 32,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture_i,
  input  logic [WW-1:0]   word_i,
  output logic [XLEN-1:0] data_o
);
  logic [WW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         word_q <= '0;
    else if (capture_i) word_q <= word_i;
  end

  generate
    if (XLEN > WW) begin : g_pad
      assign data_o = {{(XLEN-WW){1'b0}}, word_q};
    end else begin : g_flat
      assign data_o = word_q[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/lmw_seq.sv
module lmw_seq
  import lmw_pkg::*;
#(
  parameter int AW   = 64,
  parameter int XLEN = 64,
  parameter int WW   = 32,
  parameter int NREG = 32,
  localparam int RIW = $clog2(NREG),
  localparam int STEP = WW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [RIW-1:0]  start_reg_i,
  input  logic [AW-1:0]   start_addr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            rd_req_valid_o,
  input  logic            rd_req_ready_i,
  output logic [AW-1:0]   rd_req_addr_o,
  input  logic            rd_rsp_valid_i,
  output logic            rd_rsp_ready_o,
  input  logic [WW-1:0]   rd_rsp_data_i,
  output logic            gpr_we_o,
  output logic [RIW-1:0]  gpr_waddr_o,
  output logic [XLEN-1:0] gpr_wdata_o
);
  lmw_state_e     state;
  logic           load, capture, advance, last;
  logic [RIW-1:0] idx;
  logic [AW-1:0]  addr;

  lmw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .req_ready_i(rd_req_ready_i), .rsp_valid_i(rd_rsp_valid_i),
    .last_i(last), .state_o(state), .load_o(load),
    .capture_o(capture), .advance_o(advance)
  );

  lmw_step #(.AW(AW), .NREG(NREG), .STEP(STEP)) u_step (
    .clk(clk), .rst_n(rst_n), .load_i(load), .advance_i(advance),
    .start_reg_i(start_reg_i), .start_addr_i(start_addr_i),
    .idx_o(idx), .addr_o(addr), .last_o(last)
  );

  lmw_zext #(.WW(WW), .XLEN(XLEN)) u_zext (
    .clk(clk), .rst_n(rst_n), .capture_i(capture),
    .word_i(rd_rsp_data_i), .data_o(gpr_wdata_o)
  );

  assign busy_o         = (state != S_IDLE);
  assign done_o         = (state == S_DONE);
  assign rd_req_valid_o = (state == S_REQ);
  assign rd_req_addr_o  = addr;
  assign rd_rsp_ready_o = (state == S_WAIT);
  assign gpr_we_o       = (state == S_WRITE);
  assign gpr_waddr_o    = idx;

  // R6: request held with a stable address until accepted
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)));
  // R6: no new request while a response is awaited
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready_o |-> !rd_req_valid_o);
  // R9: write follows an accepted response
  p_write_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid_i && rd_rsp_ready_o) |=> gpr_we_o);
  // R4: written word equals the accepted response word
  p_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid_i && rd_rsp_ready_o) |=> (gpr_wdata_o == {{(XLEN-WW){1'b0}}, $past(rd_rsp_data_i)}));
  // R5: done follows the write of the last register
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr_we_o && gpr_waddr_o == RIW'(NREG-1)) |=> done_o);
  // R8: done is a single-cycle pulse ending the busy period
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/tb_lmw_seq.sv
module tb_lmw_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  start_reg_i = '0;
  logic [63:0] start_addr_i = '0;
  logic        busy_o, done_o, rd_req_valid_o, rd_rsp_ready_o, gpr_we_o;
  logic        rd_req_ready_i = 1'b0;
  logic        rd_rsp_valid_i = 1'b0;
  logic [31:0] rd_rsp_data_i = '0;
  logic [63:0] rd_req_addr_o, gpr_wdata_o;
  logic [4:0]  gpr_waddr_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lmw_seq dut (.*);

  logic [68:0] exp_wr_q[$];
  logic [63:0] exp_addr_q[$];

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return {a[15:0] ^ 16'h8421, a[31:16] ^ a[47:32]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [68:0] act, input logic [68:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: decisions made at the falling edge for the next rising edge
  bit          req_fire = 0, rsp_fire = 0, pending = 0;
  int          delay = 0, pat = 0;
  logic [63:0] paddr = '0;
  always @(negedge clk) begin
    if (rsp_fire) begin rd_rsp_valid_i = 1'b0; pending = 0; end
    if (req_fire) begin pending = 1; delay = pat % 3; end
    if (pending && !rd_rsp_valid_i) begin
      if (delay == 0) begin rd_rsp_valid_i = 1'b1; rd_rsp_data_i = mem_word(paddr); end
      else delay--;
    end
    pat++;
    rd_req_ready_i = (pat % 4) != 1;
    req_fire = rst_n && rd_req_valid_o && rd_req_ready_i;
    if (req_fire) begin
      logic [63:0] ea;
      ea = (exp_addr_q.size() > 0) ? exp_addr_q.pop_front() : 64'hX;
      check(!pending && rd_req_addr_o === ea, "R3 R6 request address", {5'd0, rd_req_addr_o}, {5'd0, ea});
      paddr = rd_req_addr_o;
    end
    rsp_fire = rd_rsp_valid_i && rd_rsp_ready_o;
  end

  // scoreboard monitor
  int  done_cnt = 0;
  int  last_ago = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (gpr_we_o) begin
        logic [68:0] e;
        e = (exp_wr_q.size() > 0) ? exp_wr_q.pop_front() : 69'hX;
        check({gpr_waddr_o, gpr_wdata_o} === e, "R2 R3 R4 register write", {gpr_waddr_o, gpr_wdata_o}, e);
      end
      if (last_ago == 1)
        check(done_o === 1'b1, "R5 done after last write", {68'd0, done_o}, 69'd1);
      else if (last_ago == 2)
        check(done_o === 1'b0 && busy_o === 1'b0, "R8 done one cycle then idle", {67'd0, done_o, busy_o}, 69'd0);
      else if (done_o)
        check(1'b0, "R5 unexpected done", 69'd1, 69'd0);
      if (done_o) done_cnt++;
      if (last_ago > 0) last_ago = (last_ago == 2) ? 0 : last_ago + 1;
      if (gpr_we_o && gpr_waddr_o == 5'd31) last_ago = 1;
    end
  end

  task automatic run_lmw(input logic [4:0] r0, input logic [63:0] a0, input bit poke);
    int d0;
    logic [63:0] a;
    a = a0;
    for (int r = r0; r <= 31; r++) begin
      exp_wr_q.push_back({5'(r), 32'd0, mem_word(a)});
      exp_addr_q.push_back(a);
      a = a + 64'd4;
    end
    d0 = done_cnt;
    @(negedge clk);
    start_reg_i = r0; start_addr_i = a0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; start_reg_i = 5'd3; start_addr_i = 64'hDEAD_0000;
    check(busy_o === 1'b1, "R2 busy after start", {68'd0, busy_o}, 69'd1);
    if (poke) begin
      // R7: extra starts while busy must not disturb the queued sequence
      repeat (5) @(negedge clk);
      start_i = 1'b1; @(negedge clk);
      start_i = 1'b0; repeat (7) @(negedge clk);
      start_i = 1'b1; @(negedge clk);
      start_i = 1'b0;
      check(busy_o === 1'b1, "R7 still busy after ignored start", {68'd0, busy_o}, 69'd1);
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_wr_q.size() == 0 && exp_addr_q.size() == 0, "R5 transfer count",
          69'(exp_wr_q.size()), 69'd0);
    check(busy_o === 1'b0, "R7 idle after run (no restart)", {68'd0, busy_o}, 69'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busy_o, done_o, rd_req_valid_o, rd_rsp_ready_o, gpr_we_o} === 5'b0, "R1 reset state",
          {64'd0, busy_o, done_o, rd_req_valid_o, rd_rsp_ready_o, gpr_we_o}, 69'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_rsp_ready_o === 1'b0 && gpr_we_o === 1'b0, "R9 no ready or write when idle",
          {67'd0, rd_rsp_ready_o, gpr_we_o}, 69'd0);
    run_lmw(5'd0,  64'h0000_0000_0000_1000, 1'b0);
    run_lmw(5'd30, 64'h0000_0000_FFFF_FFFC, 1'b0);
    run_lmw(5'd31, 64'h0000_0012_3456_7FF0, 1'b0);
    run_lmw(5'd17, 64'h0000_0000_0000_8000, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule